// File: doc/BRIEF.md
# Two-Beat Burst SRAM with Separate Read and Write Ports

This block models the core of a double-pumped synchronous SRAM. It has one read port and one write port, and both ports carry two-word bursts. The block runs from a single clock at twice the command rate. Alternate edges of that clock stand for the rising edges of the main clock (K phase) and of its complement (K# phase). The first edge after reset is a K edge.

A port is requested by pulling its active-low strobe down at a K edge. A write takes its first data word and byte-lane mask at that K edge, and its second word and mask at the K# edge that follows. A read returns its first word on the fourth edge after the command, which is a K edge, and its second word on the edge after that. The second word of every burst uses the command address with its lowest bit inverted.

Each port accepts at most one command every other K edge. If a read and a write arrive together straight after an idle K edge, the write is dropped.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is low and directly after it, `rvalid` is 0 and `rdata` is 0. The first clock edge after reset is a K edge, and later edges alternate K# and K.
- R2: A read accepted at K edge e drives its first word on edge e+4 and its second word on edge e+5. `rvalid` is 1 on exactly those two edges.
- R3: Beat one of every burst (read or write) uses address A. Beat two uses A with bit 0 inverted.
- R4: A write accepted at K edge e stores `wdata` and `bwe_n` as sampled at edge e for beat one. It stores them as sampled at edge e+1 for beat two.
- R5: `bwe_n[0]` low writes bits 8:0 of the word, and `bwe_n[1]` low writes bits 17:9. A lane whose bit is high keeps its old contents, so 2'b11 aborts the beat.
- R6: A read or a write is ignored when a command of the same type was accepted on the previous K edge. Strobes sampled on K# edges are ignored.
- R7: When both strobes are low at a K edge and both were high at the previous K edge, only the read is performed and the write is ignored.
- R8: On every edge where `rvalid` is 0, `rdata` is 0.
- R9: A read word reflects every write beat stored on earlier edges, including byte-masked merges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; edges alternate K and K# |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read strobe, active low, sampled on K edges |
| wr_n | input | 1 | Write strobe, active low, sampled on K edges |
| rd_addr | input | ADDR_W | Read burst address |
| wr_addr | input | ADDR_W | Write burst address |
| wdata | input | 2*BYTE_W | Write data for the current beat |
| bwe_n | input | 2 | Active-low lane enables for the current write beat |
| rdata | output | 2*BYTE_W | Read data, zero when not valid |
| rvalid | output | 1 | High on the two read output beats |

## Verification
The bench builds the block with ADDR_W=6 and BYTE_W=9. That gives a 64-word array of 18-bit words, which a first directed pass writes in full. As a result, every later read has a known value, and random addresses land on recently written words often enough to exercise read-after-write merges and beat-two writes that overlap pending reads. A two-half word of nine bits per lane lets masked writes mix old and new lanes visibly. With the small address space, the random strobe mix regularly hits same-type spacing, collisions after an idle edge, and reads whose second beat follows a write to the same word.

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [2*BYTE_W-1:0]   wdata,
  input  logic [1:0]            bwe_n,
  output logic [2*BYTE_W-1:0]   rdata,
  output logic                  rvalid
);
  localparam int DW     = 2 * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int RD_LAT = 4;
  localparam logic [ADDR_W-1:0] FLIP = ADDR_W'(1);

  logic              ph;
  logic              rd_busy, wr_busy, prev_idle;
  logic              rd_acc, wr_acc;
  logic [RD_LAT-1:0] rd_sh;
  logic [ADDR_W-1:0] rd_ap [RD_LAT];
  logic              b2_pend;
  logic [ADDR_W-1:0] b2_addr;
  logic              w2_pend;
  logic [ADDR_W-1:0] w2_addr;
  logic [DW-1:0]     mem [DEPTH];

  assign rd_acc = rst_n && !ph && !rd_n && !rd_busy;
  assign wr_acc = rst_n && !ph && !wr_n && !wr_busy && !(prev_idle && !rd_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= 1'b0;
      rd_busy   <= 1'b0;
      wr_busy   <= 1'b0;
      prev_idle <= 1'b1;
      rd_sh     <= '0;
      w2_pend   <= 1'b0;
    end else begin
      ph    <= ~ph;
      rd_sh <= {rd_sh[RD_LAT-2:0], rd_acc};
      if (!ph) begin
        rd_busy   <= rd_acc;
        wr_busy   <= wr_acc;
        prev_idle <= rd_n && wr_n;
      end
      w2_pend <= wr_acc;
    end
  end

  always_ff @(posedge clk) begin
    rd_ap[0] <= rd_addr;
    for (int i = 1; i < RD_LAT; i++) rd_ap[i] <= rd_ap[i-1];
    if (wr_acc) w2_addr <= wr_addr ^ FLIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      rvalid  <= 1'b0;
      b2_pend <= 1'b0;
      b2_addr <= '0;
    end else if (rd_sh[RD_LAT-1]) begin
      rdata   <= mem[rd_ap[RD_LAT-1]];
      rvalid  <= 1'b1;
      b2_pend <= 1'b1;
      b2_addr <= rd_ap[RD_LAT-1] ^ FLIP;
    end else if (b2_pend) begin
      rdata   <= mem[b2_addr];
      rvalid  <= 1'b1;
      b2_pend <= 1'b0;
    end else begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int h = 0; h < 2; h++) begin
      if (wr_acc && !bwe_n[h])
        mem[wr_addr][h*BYTE_W +: BYTE_W] <= wdata[h*BYTE_W +: BYTE_W];
      else if (w2_pend && !bwe_n[h])
        mem[w2_addr][h*BYTE_W +: BYTE_W] <= wdata[h*BYTE_W +: BYTE_W];
    end
  end

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  p_beat1_kedge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> ph);

  p_two_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(rvalid)) |=> !rvalid);

  p_rd_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> !$past(rd_acc, 2));

  p_wr_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |-> !$past(wr_acc, 2));

  p_wr_beat2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w2_pend |-> !wr_acc);
endmodule

// File: tb/tb_qdr_burst_sram.sv
module tb_qdr_burst_sram;
  localparam int AW = 6;
  localparam int BW = 9;
  localparam int DW = 2 * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    bwe_n = 2'b11;
  logic [DW-1:0] rdata;
  logic          rvalid;

  qdr_burst_sram #(.ADDR_W(AW), .BYTE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wdata(wdata), .bwe_n(bwe_n),
    .rdata(rdata), .rvalid(rvalid));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int ecnt = 0;
  string cur_tag = "R1";

  logic [DW-1:0] mm [1<<AW];
  logic          sv [8];
  logic [AW-1:0] sa [8];
  logic m_rbusy = 0, m_wbusy = 0, m_idle = 1, mw2 = 0;
  logic [AW-1:0] mw2a;

  function automatic logic [DW-1:0] merge_fn(logic [DW-1:0] old, logic [DW-1:0] nw, logic [1:0] be);
    logic [DW-1:0] r = old;
    if (!be[0]) r[BW-1:0] = nw[BW-1:0];
    if (!be[1]) r[DW-1:BW] = nw[DW-1:BW];
    return r;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%h expected=%h", tag, ecnt, act, exp);
    end
  endtask

  task automatic step(logic r_n, logic w_n, logic [AW-1:0] ra, logic [AW-1:0] wa,
                      logic [DW-1:0] wd, logic [1:0] be);
    logic ev;
    logic [DW-1:0] ed;
    logic kph, racc, wacc;
    int slot;
    rd_n = r_n; wr_n = w_n; rd_addr = ra; wr_addr = wa; wdata = wd; bwe_n = be;
    kph = (ecnt % 2 == 0);
    slot = ecnt % 8;
    ev = sv[slot];
    ed = ev ? mm[sa[slot]] : '0;
    sv[slot] = 0;
    if (kph) begin
      racc = !r_n && !m_rbusy;
      wacc = !w_n && !m_wbusy && !(m_idle && !r_n);
      m_rbusy = racc; m_wbusy = wacc; m_idle = r_n && w_n;
      if (racc) begin
        sv[(ecnt+4)%8] = 1; sa[(ecnt+4)%8] = ra;
        sv[(ecnt+5)%8] = 1; sa[(ecnt+5)%8] = ra ^ AW'(1);
      end
      if (wacc) begin
        mm[wa] = merge_fn(mm[wa], wd, be);
        mw2 = 1; mw2a = wa ^ AW'(1);
      end
    end else if (mw2) begin
      mm[mw2a] = merge_fn(mm[mw2a], wd, be);
      mw2 = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check({cur_tag, " rvalid"}, DW'(rvalid), DW'(ev));
    check(ev ? {cur_tag, " rdata"} : "R8 idle rdata", rdata, ed);
    ecnt++;
  endtask

  task automatic nop();
    step(1, 1, '0, '0, DW'($urandom), 2'b11);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    for (int i = 0; i < 8; i++) sv[i] = 0;
    for (int i = 0; i < (1<<AW); i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check("R1 reset rvalid", DW'(rvalid), '0);
    check("R1 reset rdata", rdata, '0);
    rst_n = 1'b1;

    // R4 R3: fill every word with full two-beat writes
    cur_tag = "R4";
    for (int k = 0; k < (1<<AW)/2; k++) begin
      step(1, 0, '0, AW'(2*k), DW'(18'h01000 + k), 2'b00);
      step(1, 1, '0, '0, DW'(18'h02000 + k), 2'b00);
      nop(); nop();
    end

    // R2 R3: read an odd address, beat two goes to the even neighbour
    cur_tag = "R3";
    step(0, 1, AW'(5), '0, '0, 2'b11);
    repeat (7) nop();

    // R5: lane masks per beat
    cur_tag = "R5";
    step(1, 0, '0, AW'(8), 18'h3ABCD, 2'b10);
    step(1, 1, '0, '0, 18'h15555, 2'b11);
    nop(); nop();
    step(1, 0, '0, AW'(10), 18'h3FFFF, 2'b01);
    step(1, 1, '0, '0, 18'h12345, 2'b10);
    nop(); nop();
    step(0, 1, AW'(8), '0, '0, 2'b11);
    nop(); nop(); nop();
    step(0, 1, AW'(10), '0, '0, 2'b11);
    repeat (7) nop();

    // R6: same-type command on the next K edge is ignored
    cur_tag = "R6";
    step(0, 0, AW'(12), AW'(20), 18'h0AAAA, 2'b00);
    step(0, 0, AW'(14), AW'(22), 18'h05555, 2'b00);
    step(0, 0, AW'(16), AW'(24), 18'h11111, 2'b00);
    step(0, 0, AW'(18), AW'(26), 18'h22222, 2'b00);
    repeat (6) nop();
    step(0, 1, AW'(24), '0, '0, 2'b11);
    repeat (7) nop();

    // R7: both strobes after an idle K edge drop the write
    cur_tag = "R7";
    step(0, 0, AW'(30), AW'(30), 18'h33333, 2'b00);
    step(1, 1, '0, '0, 18'h33333, 2'b00);
    repeat (6) nop();
    step(0, 1, AW'(30), '0, '0, 2'b11);
    repeat (7) nop();

    // R9: random mix checked against the model
    cur_tag = "R9";
    for (int n = 0; n < 6000; n++)
      step(($urandom % 2) != 0, ($urandom % 2) != 0, AW'($urandom), AW'($urandom),
           DW'($urandom), 2'($urandom));
    repeat (8) nop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule